// File: doc/BRIEF.md
# Flip-reducing differential line writer

This block takes a cache-line write request and commits it to a slow, wear-limited nonvolatile array one chunk at a time. For each chunk it first fetches what is stored, then builds two candidates for the new value: the plain data with a clear flag, and the bitwise complement with a set flag. It counts how many cells each candidate would reprogram, counting the flag cell as well. It keeps the cheaper candidate and issues a write with a per-bit enable mask that covers only the cells that really change. A chunk whose stored image already matches the cheaper candidate gets no write cycle at all.

Every chunk carries one flag cell beside its data. A set flag means the stored bits are the complement of the logical value. A host read port shares the array read path while the block is idle and returns decoded logical data, so software never sees the physical encoding. The block takes a new line only when it is idle. It raises `busy` while it walks the chunks and pulses `done` once the last chunk has been handled.

Top module: `flip_line_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `rd_en`, `wr_en` and `hrd_valid` are all 0.
- R2: A request is accepted only at a clock edge where the block is idle. `busy` is 1 from the cycle after acceptance up to and including the `done` cycle. A `req_valid` raised while `busy` is 1 is ignored and causes no later write.
- R3: Chunks are handled in ascending index order. Chunk k is read in cycle 2k+1 after acceptance, and its write, if any, is issued in cycle 2k+2 with the same chunk index. `done` is a one-cycle pulse in cycle 2*NCHUNK+1.
- R4: The flag cell is 1 when the chunk is stored inverted. The inverted form is chosen only when its cost is strictly lower than the regular form's cost. The cost is the number of data cells that differ from the stored bits, plus 1 if the flag cell differs.
- R5: `wr_mask` bit i is 1 exactly where the written physical bit differs from the stored physical bit. `wr_flag_en` is 1 exactly when the new flag differs from the stored flag.
- R6: A chunk whose cheaper form costs zero issues no `wr_en` cycle. The number of cells programmed for a line equals the sum of the per-chunk minimum costs.
- R7: `hrd_en` in an idle cycle reads the addressed chunk. In the next cycle `hrd_valid` is 1 and `hrd_data` equals the stored bits, each one inverted when the stored flag is 1.
- R8: `hrd_en` while `busy` is 1 has no effect, and `hrd_valid` stays 0.
- R9: A host read in the same cycle as a request acceptance is served, and it returns the contents from before the write.
- R10: After `done`, reading back every chunk of the line returns the requested data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Line write request |
| req_addr | input | ADDR_W | Line address |
| req_data | input | LINE_W | Logical line data, chunk 0 in the low bits |
| busy | output | 1 | Write sequence in progress |
| done | output | 1 | One-cycle pulse after the last chunk |
| hrd_en | input | 1 | Host read request (idle only) |
| hrd_addr | input | ADDR_W | Host read line address |
| hrd_chunk | input | IDX_W | Host read chunk index |
| hrd_valid | output | 1 | Host read data valid |
| hrd_data | output | CHUNK_W | Decoded logical chunk |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | ADDR_W | Array read line address |
| rd_chunk | output | IDX_W | Array read chunk index |
| rd_data | input | CHUNK_W | Stored physical chunk, one cycle after rd_en |
| rd_flag | input | 1 | Stored inversion flag, one cycle after rd_en |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | ADDR_W | Array write line address |
| wr_chunk | output | IDX_W | Array write chunk index |
| wr_data | output | CHUNK_W | Physical data to program |
| wr_flag | output | 1 | Inversion flag to program |
| wr_mask | output | CHUNK_W | Per-bit program enable |
| wr_flag_en | output | 1 | Program enable for the flag cell |

## Verification
The array read port is shared by two users: the host read, and the first chunk read of a newly accepted line. The acceptance edge and a host read can therefore land on the same edge. The bench raises `hrd_en` and `req_valid` together. It expects the host data in the next cycle to be the old logical contents, and the line to be rewritten correctly afterwards. It then holds `hrd_en` and a second request high through the busy window, and expects no `hrd_valid` and no trace of the second line in the array.

// File: rtl/flw_pkg.sv
// Shared types for the flip-reducing line writer.
// Assumes: nothing beyond a 2-bit state encoding.
package flw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EVAL = 2'd2,
        ST_DONE = 2'd3
    } flw_state_t;
endpackage

// File: rtl/flw_popcnt.sv
// Population count of a W-bit vector.
// Assumes: OUT_W is wide enough to hold W.
module flw_popcnt #(
    parameter int W     = 8,
    parameter int OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [OUT_W-1:0] cnt
);
    // Sum the set bits.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + OUT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/flw_chunk_enc.sv
// Chooses the regular or inverted encoding of one chunk against its
// stored physical image, and forms the per-bit program mask.
// Assumes: old_d/old_f are the physical cells as they are stored now.
module flw_chunk_enc #(
    parameter int CHUNK_W = 8
) (
    input  logic [CHUNK_W-1:0] new_d,
    input  logic [CHUNK_W-1:0] old_d,
    input  logic               old_f,
    output logic [CHUNK_W-1:0] wdata,
    output logic               wflag,
    output logic [CHUNK_W-1:0] wmask,
    output logic               wflag_en,
    output logic               any_chg
);
    localparam int CNT_W = $clog2(CHUNK_W + 2);

    logic [CHUNK_W-1:0] diff_reg, diff_inv;
    logic [CNT_W-1:0]   pc_reg, pc_inv, cost_reg, cost_inv;
    logic               use_inv;

    // Cell differences for each candidate.
    always_comb begin
        diff_reg = new_d ^ old_d;
        diff_inv = ~new_d ^ old_d;
    end

    flw_popcnt #(.W(CHUNK_W), .OUT_W(CNT_W)) u_pc_reg (.vec(diff_reg), .cnt(pc_reg));
    flw_popcnt #(.W(CHUNK_W), .OUT_W(CNT_W)) u_pc_inv (.vec(diff_inv), .cnt(pc_inv));

    // Cost includes the flag cell; ties keep the regular form.
    always_comb begin
        cost_reg = pc_reg + CNT_W'(old_f);
        cost_inv = pc_inv + CNT_W'(!old_f);
        use_inv  = cost_inv < cost_reg;
        wdata    = use_inv ? ~new_d : new_d;
        wflag    = use_inv;
        wmask    = use_inv ? diff_inv : diff_reg;
        wflag_en = wflag != old_f;
        any_chg  = (|wmask) | wflag_en;
    end
endmodule

// File: rtl/flw_ctrl.sv
// Sequencer: captures a line when idle, then alternates read and
// evaluate cycles per chunk in ascending order, then one done cycle.
// Assumes: the array returns read data one cycle after the read strobe.
module flw_ctrl
    import flw_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LINE_W  = 64,
    parameter int CHUNK_W = 8,
    localparam int NCHUNK = LINE_W / CHUNK_W,
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LINE_W-1:0]  req_data,
    output flw_state_t         st,
    output logic [IDX_W-1:0]   cur_idx,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [CHUNK_W-1:0] cur_new
);
    logic [LINE_W-1:0] line_q;

    // State, chunk index and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_idx  <= '0;
            cur_addr <= '0;
            line_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    cur_addr <= req_addr;
                    line_q   <= req_data;
                    cur_idx  <= '0;
                    st       <= ST_READ;
                end
                ST_READ: st <= ST_EVAL;
                ST_EVAL: begin
                    if (cur_idx == IDX_W'(NCHUNK - 1)) begin
                        st <= ST_DONE;
                    end else begin
                        cur_idx <= cur_idx + 1'b1;
                        st      <= ST_READ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Logical new data of the chunk under work.
    always_comb cur_new = line_q[cur_idx*CHUNK_W +: CHUNK_W];

    // R3: the index never runs past the last chunk.
    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (int'(cur_idx) < NCHUNK));
endmodule

// File: rtl/flip_line_writer.sv
// Differential line writer: read-compare-write per chunk with a
// per-chunk inversion flag, skipping chunks that need no cell change.
// Host reads share the array read port while idle and are decoded.
// Assumes: synchronous array, read data valid one cycle after rd_en,
// masked writes take effect at the clock edge of wr_en.
module flip_line_writer
    import flw_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LINE_W  = 64,
    parameter int CHUNK_W = 8,
    localparam int NCHUNK = LINE_W / CHUNK_W,
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LINE_W-1:0]  req_data,
    output logic               busy,
    output logic               done,
    input  logic               hrd_en,
    input  logic [ADDR_W-1:0]  hrd_addr,
    input  logic [IDX_W-1:0]   hrd_chunk,
    output logic               hrd_valid,
    output logic [CHUNK_W-1:0] hrd_data,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [IDX_W-1:0]   rd_chunk,
    input  logic [CHUNK_W-1:0] rd_data,
    input  logic               rd_flag,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [IDX_W-1:0]   wr_chunk,
    output logic [CHUNK_W-1:0] wr_data,
    output logic               wr_flag,
    output logic [CHUNK_W-1:0] wr_mask,
    output logic               wr_flag_en
);
    flw_state_t         st;
    logic [IDX_W-1:0]   cur_idx;
    logic [ADDR_W-1:0]  cur_addr;
    logic [CHUNK_W-1:0] cur_new;
    logic               any_chg;
    logic               host_go;

    flw_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .CHUNK_W(CHUNK_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .st(st), .cur_idx(cur_idx), .cur_addr(cur_addr), .cur_new(cur_new)
    );

    flw_chunk_enc #(.CHUNK_W(CHUNK_W)) u_enc (
        .new_d(cur_new), .old_d(rd_data), .old_f(rd_flag),
        .wdata(wr_data), .wflag(wr_flag), .wmask(wr_mask),
        .wflag_en(wr_flag_en), .any_chg(any_chg)
    );

    // Status and read-port arbitration: host owns the port only when idle.
    always_comb begin
        busy     = st != ST_IDLE;
        done     = st == ST_DONE;
        host_go  = (st == ST_IDLE) && hrd_en;
        rd_en    = (st == ST_READ) || host_go;
        rd_addr  = host_go ? hrd_addr : cur_addr;
        rd_chunk = host_go ? hrd_chunk : cur_idx;
        wr_en    = (st == ST_EVAL) && any_chg;
        wr_addr  = cur_addr;
        wr_chunk = cur_idx;
        hrd_data = rd_data ^ {CHUNK_W{rd_flag}};
    end

    // Marks the cycle in which host read data is on rd_data.
    always_ff @(posedge clk) begin
        if (!rst_n) hrd_valid <= 1'b0;
        else        hrd_valid <= host_go;
    end

    assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && ($past(rd_chunk) == wr_chunk)));
    assert_min_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (($countones(wr_mask) + int'(wr_flag_en)) <= (CHUNK_W + 1) / 2));
    assert_host_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hrd_valid |-> $past(!busy));
endmodule

// File: tb/sim_flip_line_writer.sv
`timescale 1ns/1ps
module sim_flip_line_writer;
    localparam int AW = 4;
    localparam int LW = 64;
    localparam int CW = 8;
    localparam int N  = LW / CW;
    localparam int IW = $clog2(N);
    localparam int NV = 8;

    // Stimulus table: {address, line data}.
    localparam logic [AW+LW-1:0] VEC [NV] = '{
        {4'd3, 64'h0000_0000_0000_0000},
        {4'd3, 64'hFFFF_FFFF_FFFF_FFFF},
        {4'd3, 64'h0F0F_0F0F_0F0F_0F0F},
        {4'd3, 64'h0F0F_0F0F_0F0F_0F0F},
        {4'd3, 64'h0F0F_0F0F_FFFF_0001},
        {4'd7, 64'h0123_4567_89AB_CDEF},
        {4'd7, 64'hFEDC_BA98_7654_3210},
        {4'd3, 64'h0000_0000_0000_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_data = '0;
    logic busy, done, hrd_valid, rd_en, rd_flag, wr_en, wr_flag, wr_flag_en;
    logic hrd_en = 1'b0;
    logic [AW-1:0] hrd_addr = '0;
    logic [IW-1:0] hrd_chunk = '0;
    logic [CW-1:0] hrd_data, rd_data, wr_data, wr_mask;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [IW-1:0] rd_chunk, wr_chunk;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errs = 0, wr_tot = 0, bit_tot = 0, last_chunk = -1;
    logic [LW-1:0] mon_data = '0;
    logic [AW-1:0] mon_addr = '0;

    always #2.5 clk = ~clk;

    flip_line_writer #(.ADDR_W(AW), .LINE_W(LW), .CHUNK_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .hrd_en(hrd_en),
        .hrd_addr(hrd_addr), .hrd_chunk(hrd_chunk), .hrd_valid(hrd_valid),
        .hrd_data(hrd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_chunk(rd_chunk),
        .rd_data(rd_data), .rd_flag(rd_flag), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_chunk(wr_chunk), .wr_data(wr_data), .wr_flag(wr_flag),
        .wr_mask(wr_mask), .wr_flag_en(wr_flag_en)
    );

    // Array model: synchronous read, masked write.
    logic [CW-1:0] mem_d [(1<<AW)*N];
    logic          mem_f [(1<<AW)*N];
    logic [CW-1:0] rq_d;
    logic          rq_f;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW)*N; i++) begin
                mem_d[i] <= '0;
                mem_f[i] <= 1'b0;
            end
            rq_d <= '0;
            rq_f <= 1'b0;
        end else begin
            if (rd_en) begin
                rq_d <= mem_d[{rd_addr, rd_chunk}];
                rq_f <= mem_f[{rd_addr, rd_chunk}];
            end
            if (wr_en) begin
                mem_d[{wr_addr, wr_chunk}] <= (mem_d[{wr_addr, wr_chunk}] & ~wr_mask) | (wr_data & wr_mask);
                if (wr_flag_en) mem_f[{wr_addr, wr_chunk}] <= wr_flag;
            end
        end
    end
    assign rd_data = rq_d;
    assign rd_flag = rq_f;

    // Write monitor: checks every issued chunk write against the cost rule.
    always @(negedge clk) begin
        if (rst_n && done) last_chunk = -1;
        if (rst_n && wr_en) begin
            logic [CW-1:0] od, nd, ed;
            logic of, ef;
            int cr, ci;
            od = mem_d[{wr_addr, wr_chunk}];
            of = mem_f[{wr_addr, wr_chunk}];
            nd = mon_data[int'(wr_chunk)*CW +: CW];
            cr = $countones(nd ^ od) + int'(of);
            ci = $countones(~nd ^ od) + int'(!of);
            ef = ci < cr;
            ed = ef ? ~nd : nd;
            mon_checks++;
            if (wr_flag !== ef || wr_data !== ed || wr_addr !== mon_addr) begin
                mon_errs++;
                $display("FAIL R4 chunk %0d: data/flag %h/%b expected %h/%b", wr_chunk, wr_data, wr_flag, ed, ef);
            end
            mon_checks++;
            if (wr_mask !== (ed ^ od) || wr_flag_en !== (ef != of)) begin
                mon_errs++;
                $display("FAIL R5 chunk %0d: mask/flag_en %h/%b expected %h/%b", wr_chunk, wr_mask, wr_flag_en, ed ^ od, ef != of);
            end
            mon_checks++;
            if (int'(wr_chunk) <= last_chunk) begin
                mon_errs++;
                $display("FAIL R3 chunk order: got %0d expected above %0d", wr_chunk, last_chunk);
            end
            last_chunk = int'(wr_chunk);
            wr_tot++;
            bit_tot += $countones(wr_mask) + int'(wr_flag_en);
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hread(input logic [AW-1:0] a, input int c, output logic v, output logic [CW-1:0] d);
        hrd_en = 1'b1; hrd_addr = a; hrd_chunk = IW'(c);
        @(negedge clk);
        hrd_en = 1'b0;
        v = hrd_valid; d = hrd_data;
    endtask

    task automatic readback(input logic [AW-1:0] a, input logic [LW-1:0] line);
        for (int c = 0; c < N; c++) begin
            logic v;
            logic [CW-1:0] d;
            hread(a, c, v, d);
            check("R7 host read valid", 64'(v), 64'd1);
            check("R10 readback", 64'(d), 64'(line[c*CW +: CW]));
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [LW-1:0] line);
        int exp_w, exp_b, w0, b0, lat;
        exp_w = 0; exp_b = 0;
        for (int c = 0; c < N; c++) begin
            logic [CW-1:0] od, nd;
            int cr, ci, m;
            od = mem_d[{a, IW'(c)}];
            nd = line[c*CW +: CW];
            cr = $countones(nd ^ od) + int'(mem_f[{a, IW'(c)}]);
            ci = $countones(~nd ^ od) + int'(!mem_f[{a, IW'(c)}]);
            m = (ci < cr) ? ci : cr;
            if (m > 0) exp_w++;
            exp_b += m;
        end
        w0 = wr_tot; b0 = bit_tot;
        mon_data = line; mon_addr = a;
        req_valid = 1'b1; req_addr = a; req_data = line;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            check("R2 busy during sequence", 64'(busy), 64'd1);
            @(negedge clk);
            lat++;
        end
        check("R3 done latency", 64'(lat), 64'(2*N+1));
        check("R2 busy at done", 64'(busy), 64'd1);
        @(negedge clk);
        check("R3 done is one pulse", 64'(done), 64'd0);
        check("R2 idle after done", 64'(busy), 64'd0);
        check("R6 write cycles", 64'(wr_tot - w0), 64'(exp_w));
        check("R6 cells programmed", 64'(bit_tot - b0), 64'(exp_b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", 64'(busy), 64'd0);
        check("R1 reset done", 64'(done), 64'd0);
        check("R1 reset rd_en", 64'(rd_en), 64'd0);
        check("R1 reset wr_en", 64'(wr_en), 64'd0);
        check("R1 reset hrd_valid", 64'(hrd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset busy", 64'(busy | done | wr_en | hrd_valid), 64'd0);

        // Table-driven writes, each followed by a full readback.
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][AW+LW-1:LW], VEC[v][LW-1:0]);
            readback(VEC[v][AW+LW-1:LW], VEC[v][LW-1:0]);
        end

        // R9: host read on the acceptance edge sees pre-write data (line 7 holds VEC[6]).
        begin
            logic [LW-1:0] nl, other;
            int guard;
            nl = 64'hA5A5_5A5A_C3C3_3C3C;
            other = 64'h1111_2222_3333_4444;
            mon_data = nl; mon_addr = 4'd7;
            req_valid = 1'b1; req_addr = 4'd7; req_data = nl;
            hrd_en = 1'b1; hrd_addr = 4'd7; hrd_chunk = IW'(2);
            @(negedge clk);
            req_valid = 1'b0;
            check("R9 shared-edge host valid", 64'(hrd_valid), 64'd1);
            check("R9 shared-edge old data", 64'(hrd_data), 64'(VEC[6][2*CW +: CW]));
            // R8/R2: host read and a second request while busy.
            hrd_chunk = '0;
            req_valid = 1'b1; req_addr = 4'd7; req_data = other;
            @(negedge clk);
            req_valid = 1'b0;
            guard = 0;
            while (!done && guard < 100) begin
                check("R8 host read ignored while busy", 64'(hrd_valid), 64'd0);
                @(negedge clk);
                guard++;
            end
            hrd_en = 1'b0;
            @(negedge clk);
            check("R8 no late host valid", 64'(hrd_valid), 64'd0);
            repeat (4) begin
                @(negedge clk);
                check("R2 request while busy dropped", 64'(busy), 64'd0);
            end
            readback(4'd7, nl);
        end

        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end
endmodule